// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one timer channel that turns a 16-bit up-counter into a pulse-width-modulated output. Software programs it through a small word-wide register port. Four registers are reachable: a control word, a period limit, an activation threshold and the live count. The counter advances on prescaled ticks. The source of those ticks is either the bus clock or the rising edges of an asynchronous external clock input. The prescaler divides the source by a power of four.

Within each period the output stays inactive until the counter reaches the threshold, and it is active from that point until the counter wraps. Software programs the threshold as the period length minus the wanted active time. An output-enable bit gates the waveform onto the pin, and this gate is separate from the counter-enable bit. A polarity bit chooses which level counts as active. A shutdown-mode bit decides what happens when the output enable is cleared. Either the output drops to its inactive level at once, or the current period runs to its end first. Writing the count register restarts the counter from zero.

Top module: `pwmt_channel`

## Requirements
- R1: After reset, every register reads zero and `pwm_o` is low.
- R2: The address encoding is 0 control, 1 period, 2 threshold, 3 count. A control read returns bits 7:0 as last written, with bits 15:8 reading zero. Period and threshold read back as written.
- R3: Control bit 4 enables counting. With bit 3 clear and prescaler field 0, the count (read at address 3) advances once per bus clock cycle. It wraps from period-1 to 0. A period of 0 or 1 holds it at 0, and with bit 4 clear it holds its value.
- R4: Control bits 2:0 hold the prescaler selector n. The count advances once every 4^n source ticks. Selector values 6 and 7 act as 5.
- R5: When control bit 3 is set, each rising edge of `ext_clk_i` is one source tick. The count moves within three bus clock cycles of the edge and does not move without edges.
- R6: A write to address 3, whatever its data, sets the count and the prescaler phase to zero.
- R7: While the output is gated on, the active level is driven exactly when threshold < period and count >= threshold. A threshold of 0 is active for the whole period, and a threshold >= period is never active.
- R8: Control bit 6 set makes the active level low and the inactive level high. With the bit clear the active level is high.
- R9: Control bit 5 is the output enable. When it is clear and no drain is in progress, `pwm_o` holds the inactive level while the counter runs.
- R10: When control bit 7 (abrupt) is set, a write that clears bit 5 forces the inactive level in the cycle the write takes effect.
- R11: When bit 7 is clear, clearing bit 5 while counting keeps the waveform until the counter next wraps to 0, and the level is inactive from then on. A write that wraps at that same edge drops the output at once. Stopping the counter or writing the count also ends the drain at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest situation to reach is the graceful drain. The output enable has to fall at a chosen phase of a running period, including the edge on which the counter itself wraps. The bench starts a fixed waveform and then delays the clearing write by every offset from 0 to 7 cycles, so that all counter phases are covered, the wrap edge among them. It reads the live count each cycle and expects the active level only until the first zero it observes. The same sweep is repeated with the abrupt bit set, and once with the counter stopped in the middle of a drain.

// File: rtl/pwmt_pkg.sv
// Package: shared types and constants of the PWM timer channel.
// Assumes an 8-bit control word and a 2-bit register address.
package pwmt_pkg;

    localparam int CTRL_W    = 8;
    localparam int PRE_SEL_W = 3;

    // Register map of the channel
    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_PERIOD = 2'd1,
        A_DUTY   = 2'd2,
        A_COUNT  = 2'd3
    } reg_addr_e;

    // Control word, MSB first
    typedef struct packed {
        logic                 abrupt;     // bit 7
        logic                 active_low; // bit 6
        logic                 out_en;     // bit 5
        logic                 count_en;   // bit 4
        logic                 src_ext;    // bit 3
        logic [PRE_SEL_W-1:0] pre_sel;    // bits 2:0
    } ctrl_t;

endpackage

// File: rtl/pwmt_prescaler.sv
// Module: source-tick selection and power-of-four prescaler.
// Synchronises the external clock and detects its rising edges. Picks the
// bus clock or those edges as source ticks, and emits one tick every 4^n
// source ticks. Selectors at or above PRE_STEPS are clamped to the largest step.
// Assumes ext_clk_i is asynchronous and slower than clk/2.
module pwmt_prescaler #(
    parameter int PRE_STEPS = 6,
    parameter int SEL_W     = 3,
    localparam int PRE_W    = 2 * (PRE_STEPS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             src_ext,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);

    logic [2:0]       ext_sync_q;
    logic             ext_rise;
    logic             src_tick;
    logic [SEL_W-1:0] sel_eff;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_q;

    // Two-stage synchroniser plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync_q <= '0;
        else        ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};
    end

    assign ext_rise = ext_sync_q[1] & ~ext_sync_q[2];
    assign src_tick = src_ext ? ext_rise : 1'b1;

    // Clamp the selector and derive the terminal value of the divider
    always_comb begin
        sel_eff = (sel >= SEL_W'(PRE_STEPS)) ? SEL_W'(PRE_STEPS - 1) : sel;
        limit   = PRE_W'((32'd1 << (2 * int'(sel_eff))) - 32'd1);
    end

    // Divider phase counter; restarts when stopped or cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            pre_q <= '0;
        end else if (src_tick) begin
            pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick_o = run && src_tick && (pre_q == limit);

endmodule

// File: rtl/pwmt_counter.sv
// Module: period counter of the PWM channel.
// Advances on each prescaled tick and wraps to zero on the tick that
// would make it reach the period value, so it spans 0..period-1. A clear
// overrides a tick. Assumes the period may change at any time; a lower
// period causes a wrap on the next tick.
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             at_end;

    // Detect the end of the period from the incremented value
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        at_end  = cnt_inc >= {1'b0, period};
    end

    // Count register with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= at_end ? '0 : cnt_inc[CNT_W-1:0];
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick && !clear && at_end;

endmodule

// File: rtl/pwmt_regs.sv
// Module: register file and read multiplexer of the PWM channel.
// Holds the control, period and threshold registers, flags control and
// count writes to neighbouring logic, and returns read data combinationally.
// Assumes CNT_W >= CTRL_W.
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] duty_q,
    output logic             ctrl_wr,
    output ctrl_t            ctrl_new,
    output logic             cnt_clear,
    output logic [CNT_W-1:0] rdata
);

    reg_addr_e sel_addr;

    assign sel_addr  = reg_addr_e'(addr);
    assign ctrl_new  = ctrl_t'(wdata[CTRL_W-1:0]);
    assign ctrl_wr   = wr_en && (sel_addr == A_CTRL);
    assign cnt_clear = wr_en && (sel_addr == A_COUNT);

    // Storage of the writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            duty_q   <= '0;
        end else if (wr_en) begin
            case (sel_addr)
                A_CTRL:   ctrl_q   <= ctrl_new;
                A_PERIOD: period_q <= wdata;
                A_DUTY:   duty_q   <= wdata;
                default:  ;
            endcase
        end
    end

    // Read multiplexer; the count is read live
    always_comb begin
        case (sel_addr)
            A_CTRL:   rdata = {{(CNT_W - CTRL_W){1'b0}}, ctrl_q};
            A_PERIOD: rdata = period_q;
            A_DUTY:   rdata = duty_q;
            default:  rdata = cnt;
        endcase
    end

endmodule

// File: rtl/pwmt_wave.sv
// Module: compare, polarity and output gating of the PWM channel.
// The raw waveform is active from the threshold to the end of the period.
// The gate is the output enable or a pending drain. A drain starts when a
// control write clears the enable in graceful mode while counting. It ends
// on a wrap, a count write, a stop, or a switch to abrupt mode.
module pwmt_wave
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_q,
    input  logic             ctrl_wr,
    input  ctrl_t            ctrl_new,
    input  logic             cnt_clear,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_o
);

    logic drain_q;
    logic gate;
    logic raw_active;

    // Graceful-shutdown drain flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0;
        end else if (ctrl_wr) begin
            drain_q <= (ctrl_q.out_en || drain_q) && !ctrl_new.out_en
                       && !ctrl_new.abrupt && ctrl_new.count_en && !wrap;
        end else if (wrap || cnt_clear || !ctrl_q.count_en
                     || ctrl_q.abrupt || ctrl_q.out_en) begin
            drain_q <= 1'b0;
        end
    end

    // Threshold compare, gating and polarity
    always_comb begin
        raw_active = (duty < period) && (cnt >= duty);
        gate       = ctrl_q.out_en || drain_q;
        pwm_o      = gate ? (raw_active ^ ctrl_q.active_low) : ctrl_q.active_low;
    end

endmodule

// File: rtl/pwmt_channel.sv
// Module: top level of one prescaled PWM timer channel.
// Connects the register file, prescaler, counter and waveform stage. All
// logic runs on clk; the external count clock is only sampled.
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_STEPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             pwm_o
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             ctrl_wr;
    logic             cnt_clear;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             wrap;

    pwmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .cnt       (cnt_q),
        .ctrl_q    (ctrl_q),
        .period_q  (period_q),
        .duty_q    (duty_q),
        .ctrl_wr   (ctrl_wr),
        .ctrl_new  (ctrl_new),
        .cnt_clear (cnt_clear),
        .rdata     (rdata_o)
    );

    pwmt_prescaler #(.PRE_STEPS(PRE_STEPS), .SEL_W(PRE_SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .src_ext   (ctrl_q.src_ext),
        .run       (ctrl_q.count_en),
        .clear     (cnt_clear),
        .sel       (ctrl_q.pre_sel),
        .tick_o    (tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clear  (cnt_clear),
        .period (period_q),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    pwmt_wave #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_q    (ctrl_q),
        .ctrl_wr   (ctrl_wr),
        .ctrl_new  (ctrl_new),
        .cnt_clear (cnt_clear),
        .wrap      (wrap),
        .cnt       (cnt_q),
        .period    (period_q),
        .duty      (duty_q),
        .pwm_o     (pwm_o)
    );

endmodule

// File: rtl/pwmt_checker.sv
// Module: assertion checker for pwmt_channel, attached by bind.
// Relates register-port writes, held state and the PWM output over time.
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [1:0]       addr_i,
    input logic [CTRL_W-1:0] wdata_lo,
    input logic             pwm_o,
    input ctrl_t            ctrl_q,
    input logic [CNT_W-1:0] period_q,
    input logic [CNT_W-1:0] duty_q,
    input logic [CNT_W-1:0] cnt_q
);

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0) |=> ctrl_q == ctrl_t'($past(wdata_lo))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1)); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.count_en && !(wr_en_i && addr_i == 2'd3)) |=> $stable(cnt_q)); // R3

    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd3) |=> cnt_q == '0); // R6

    AST_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q >= period_q) |-> pwm_o == ctrl_q.active_low); // R7

    AST_ABRUPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.out_en && (ctrl_q.abrupt || !ctrl_q.count_en))
        |-> pwm_o == ctrl_q.active_low); // R10

    AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.out_en && cnt_q == '0 && $past(cnt_q) != '0)
        |-> pwm_o == ctrl_q.active_low); // R11

endmodule

bind pwmt_channel pwmt_checker #(.CNT_W(CNT_W)) u_pwmt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_lo (wdata_i[pwmt_pkg::CTRL_W-1:0]),
    .pwm_o    (pwm_o),
    .ctrl_q   (ctrl_q),
    .period_q (period_q),
    .duty_q   (duty_q),
    .cnt_q    (cnt_q)
);

// File: tb/test_pwmt_channel.sv
module test_pwmt_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        pwm_o;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    pwmt_channel i_pwmt_channel (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        addr_i = a;
        #1;
        d = int'(rdata_o);
    endtask

    function automatic logic [15:0] cw(input int pre, input bit ext, input bit cen,
                                       input bit oen, input bit low, input bit abr);
        return {8'h00, abr, low, oen, cen, ext, 3'(pre)};
    endfunction

    task automatic setup(input int p, input int d);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'(p));
        wr(2'd2, 16'(d));
    endtask

    // Graceful or abrupt shutdown after a phase offset; P=8, threshold 3
    task automatic shutdown_run(input int off, input bit abr);
        int  c;
        bit  wrapped;
        bit  expv;
        setup(8, 3);
        wr(2'd0, cw(0, 0, 1, 1, 0, abr));
        repeat (off) @(negedge clk);
        wr(2'd0, cw(0, 0, 1, 0, 0, abr));
        wrapped = 1'b0;
        for (int j = 0; j < 12; j++) begin
            if (j > 0) @(negedge clk);
            rd(2'd3, c);
            if (c == 0) wrapped = 1'b1;
            expv = !abr && !wrapped && (c >= 3);
            chk(pwm_o == expv, abr ? "R10 abrupt off" : "R11 drain", int'(pwm_o), int'(expv));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int v;
        int c;
        bit expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(pwm_o == 1'b0, "R1 reset pwm", int'(pwm_o), 0);

        // R2: read-back
        wr(2'd0, 16'hFF47); rd(2'd0, v); chk(v == 16'h0047, "R2 ctrl readback", v, 16'h0047);
        wr(2'd1, 16'hABCD); rd(2'd1, v); chk(v == 16'hABCD, "R2 period readback", v, 16'hABCD);
        wr(2'd2, 16'h1234); rd(2'd2, v); chk(v == 16'h1234, "R2 duty readback", v, 16'h1234);

        // R3 and R4: prescaler sweep with P=5, counting from bus clock
        for (int n = 0; n < 8; n++) begin
            int m;
            m = (n > 5) ? 5 : n;
            setup(5, 9);
            wr(2'd0, cw(n, 0, 1, 0, 0, 0));
            for (int j = 0; j <= 3 * (1 << (2 * m)) + 3; j++) begin
                if (j > 0) @(negedge clk);
                rd(2'd3, c);
                v = (j >> (2 * m)) % 5;
                chk(c == v, (n == 0) ? "R3 count" : "R4 prescale", c, v);
            end
        end

        // R3: stopped counter holds its value
        wr(2'd0, cw(0, 0, 0, 0, 0, 0));
        rd(2'd3, v);
        repeat (10) @(negedge clk);
        rd(2'd3, c);
        chk(c == v, "R3 hold when stopped", c, v);

        // R6: count write clears count and prescaler phase
        setup(100, 0);
        wr(2'd0, cw(1, 0, 1, 0, 0, 0));
        repeat (13) @(negedge clk);
        wr(2'd3, 16'h5555);
        rd(2'd3, c); chk(c == 0, "R6 clear", c, 0);
        repeat (3) @(negedge clk);
        rd(2'd3, c); chk(c == 0, "R6 prescaler phase", c, 0);
        @(negedge clk);
        rd(2'd3, c); chk(c == 1, "R6 first tick after clear", c, 1);

        // R5: external clock edges
        setup(16, 0);
        wr(2'd0, cw(0, 1, 1, 0, 0, 0));
        repeat (20) @(negedge clk);
        rd(2'd3, c); chk(c == 0, "R5 no edges no count", c, 0);
        for (int i = 0; i < 10; i++) begin
            ext_clk_i = 1'b1;
            repeat (3) @(negedge clk);
            rd(2'd3, c); chk(c == i + 1, "R5 ext edge", c, i + 1);
            ext_clk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        wr(2'd3, 16'h0000);
        wr(2'd0, cw(1, 1, 1, 0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            ext_clk_i = 1'b1; repeat (3) @(negedge clk);
            ext_clk_i = 1'b0; repeat (3) @(negedge clk);
        end
        rd(2'd3, c); chk(c == 2, "R5 ext with prescale", c, 2);

        // R7 and R8: exhaustive small sweep of period, threshold, polarity
        for (int p = 0; p < 7; p++) begin
            for (int d = 0; d < 8; d++) begin
                for (int low = 0; low < 2; low++) begin
                    setup(p, d);
                    wr(2'd0, cw(0, 0, 1, 1, low[0], 0));
                    for (int j = 0; j < 2 * p + 3; j++) begin
                        if (j > 0) @(negedge clk);
                        rd(2'd3, c);
                        v = (p <= 1) ? 0 : j % p;
                        chk(c == v, "R3 count in sweep", c, v);
                        expv = ((d < p) && (v >= d)) ^ low[0];
                        chk(pwm_o == expv, low ? "R8 inverted compare" : "R7 compare",
                            int'(pwm_o), int'(expv));
                    end
                end
            end
        end

        // R9: output enable clear gives inactive level while counting
        for (int low = 0; low < 2; low++) begin
            setup(6, 0);
            wr(2'd0, cw(0, 0, 1, 0, low[0], 0));
            for (int j = 0; j < 12; j++) begin
                @(negedge clk);
                #1;
                chk(pwm_o == low[0], "R9 gate off", int'(pwm_o), low);
            end
        end

        // R10 and R11: shutdown at every phase
        for (int off = 0; off < 8; off++) begin
            shutdown_run(off, 1'b0);
            shutdown_run(off, 1'b1);
        end

        // R11: stopping the counter ends a drain at once
        setup(8, 0);
        wr(2'd0, cw(0, 0, 1, 1, 0, 0));
        repeat (2) @(negedge clk);
        wr(2'd0, cw(0, 0, 1, 0, 0, 0));
        #1;
        chk(pwm_o == 1'b1, "R11 drain active", int'(pwm_o), 1);
        wr(2'd0, cw(0, 0, 0, 0, 0, 0));
        #1;
        chk(pwm_o == 1'b0, "R11 stop ends drain", int'(pwm_o), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule